// File: doc/BRIEF.md
# Reorder Buffer with In-Order Retirement

This block is a circular buffer that holds every in-flight instruction in program order. When the rename stage dispatches an instruction, the block gives it a slot at the tail and records which architectural register the instruction will write, if any. The slot index goes back to the requester as the rename tag. Consumers use this tag to find the producer of a source operand.

Execution units finish in any order. They return results on a bus that carries the tag, and the result is stored in the matching slot, which is then marked complete. The architectural state is not updated at this point. Retirement looks only at the oldest slot. Once that slot is complete, the block presents its value to the architectural register file and frees the slot. A younger result that finished early therefore stays hidden until every older instruction has retired.

Read ports return the stored value and the completion status of any slot. A flush input discards everything in flight in a single cycle.

Top module: `reorder_buffer`

## Requirements
- R1: After reset, and in the cycle after `flush` is high, the buffer is empty: `empty`=1, `full`=0, `commit_valid`=0 and every `rd_ready` bit is 0. The next grant after that carries tag 0. While `flush` is high, both `disp_grant` and `commit_valid` are 0.
- R2: `disp_grant` is 1 exactly when `disp_req`=1, `rs_avail`=1, `flush`=0 and the buffer is not full. `disp_tag` then gives the allocated slot index.
- R3: `full` is 1 when DEPTH slots are occupied. While full, a dispatch is refused, even in a cycle where the head retires.
- R4: A result with `wb_valid`=1 and a `wb_tag` that names an occupied slot stores `wb_data` in that slot and marks it complete from the next cycle on. A result that names a free slot is ignored.
- R5: Each read port reports `rd_ready`=1 only for an occupied and completed slot, together with that slot's stored value. A slot that was just allocated reads as not ready.
- R6: `commit_valid` is 1 only when the oldest slot is occupied and complete. `commit_areg` and `commit_data` then carry that slot's register and value, and the head moves on at the next clock edge.
- R7: A younger slot that completed before an older one is not presented for commit until the older one has retired.
- R8: A slot dispatched with `disp_has_dst`=0 still retires with `commit_valid`=1, but with `commit_wen`=0.
- R9: Tags are handed out in increasing order and wrap from DEPTH-1 back to 0.
- R10: `empty` is 1 exactly when no slot is occupied, and `commit_valid` is 0 while empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| flush | input | 1 | Discard all in-flight slots |
| disp_req | input | 1 | Request to allocate a slot |
| rs_avail | input | 1 | A downstream scheduler slot is free |
| disp_has_dst | input | 1 | Instruction writes an architectural register |
| disp_areg | input | AREG_W | Destination architectural register |
| disp_grant | output | 1 | Allocation accepted this cycle |
| disp_tag | output | TAG_W | Slot index (rename tag) given to the instruction |
| wb_valid | input | 1 | Result bus carries a result |
| wb_tag | input | TAG_W | Slot the result belongs to |
| wb_data | input | DATA_W | Result value |
| rd_tag | input | NUM_RD*TAG_W | Slot index per read port |
| rd_ready | output | NUM_RD | Slot occupied and complete, per port |
| rd_data | output | NUM_RD*DATA_W | Stored value, per port |
| commit_valid | output | 1 | Oldest slot retires this cycle |
| commit_wen | output | 1 | Retiring slot writes the register file |
| commit_areg | output | AREG_W | Register written at retirement |
| commit_data | output | DATA_W | Value written at retirement |
| full | output | 1 | All slots occupied |
| empty | output | 1 | No slot occupied |

## Verification
If the head pointer is corrupted, the wrong register or value appears on the commit outputs in the very next retiring cycle. A stuck completion bit shows up as a retirement that never comes, or as a read port reporting ready too early. If the occupancy count drifts, `full` or `empty` change state one allocation early or late, and a grant becomes visible to a refused dispatch or the reverse. Tag wrap mistakes show up on `disp_tag` at the first allocation after slot DEPTH-1.

// File: rtl/rob_pkg.sv
package rob_pkg;
    localparam int unsigned ROB_DEPTH_DEF    = 8;
    localparam int unsigned ROB_DATA_W_DEF   = 32;
    localparam int unsigned ROB_AREG_W_DEF   = 5;
    localparam int unsigned ROB_RD_PORTS_DEF = 2;

    // Circular increment for any depth, not only powers of two.
    function automatic logic [31:0] ring_next(input logic [31:0] idx, input logic [31:0] depth);
        return (idx + 32'd1 == depth) ? 32'd0 : idx + 32'd1;
    endfunction
endpackage

// File: rtl/rob_ctrl.sv
module rob_ctrl
    import rob_pkg::*;
#(
    parameter int unsigned DEPTH = ROB_DEPTH_DEF,
    parameter int unsigned TAG_W = $clog2(DEPTH),
    parameter int unsigned CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             flush,
    input  logic             alloc,
    input  logic             retire,
    output logic [TAG_W-1:0] head,
    output logic [TAG_W-1:0] tail,
    output logic             full,
    output logic             empty
);
    typedef struct packed {
        logic [TAG_W-1:0] head;
        logic [TAG_W-1:0] tail;
        logic [CNT_W-1:0] count;
    } ptr_state_t;

    ptr_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (flush) begin
            st_d = '0;
        end else begin
            if (alloc)
                st_d.tail = TAG_W'(ring_next(32'(st_q.tail), 32'(DEPTH)));
            if (retire)
                st_d.head = TAG_W'(ring_next(32'(st_q.head), 32'(DEPTH)));
            case ({alloc, retire})
                2'b10:   st_d.count = st_q.count + 1'b1;
                2'b01:   st_d.count = st_q.count - 1'b1;
                default: st_d.count = st_q.count;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign head  = st_q.head;
    assign tail  = st_q.tail;
    assign full  = (st_q.count == CNT_W'(DEPTH));
    assign empty = (st_q.count == '0);

    // R3
    count_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.count <= CNT_W'(DEPTH));
    // R3
    no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        alloc |-> !full);
    // R1
    flush_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> (empty && head == '0 && tail == '0));
    // R9
    tail_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (alloc && !flush && tail == TAG_W'(DEPTH - 1)) |=> tail == '0);
endmodule

// File: rtl/rob_store.sv
module rob_store
    import rob_pkg::*;
#(
    parameter int unsigned DEPTH  = ROB_DEPTH_DEF,
    parameter int unsigned DATA_W = ROB_DATA_W_DEF,
    parameter int unsigned AREG_W = ROB_AREG_W_DEF,
    parameter int unsigned NUM_RD = ROB_RD_PORTS_DEF,
    parameter int unsigned TAG_W  = $clog2(DEPTH)
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     flush,
    input  logic                     alloc,
    input  logic [TAG_W-1:0]         alloc_idx,
    input  logic                     alloc_dst,
    input  logic [AREG_W-1:0]        alloc_areg,
    input  logic                     wb_valid,
    input  logic [TAG_W-1:0]         wb_idx,
    input  logic [DATA_W-1:0]        wb_data,
    input  logic                     retire,
    input  logic [TAG_W-1:0]         head_idx,
    output logic                     head_valid,
    output logic                     head_ready,
    output logic                     head_dst,
    output logic [AREG_W-1:0]        head_areg,
    output logic [DATA_W-1:0]        head_data,
    input  logic [NUM_RD*TAG_W-1:0]  rd_tag,
    output logic [NUM_RD-1:0]        rd_ready,
    output logic [NUM_RD*DATA_W-1:0] rd_data
);
    typedef struct packed {
        logic [DEPTH-1:0]             valid;
        logic [DEPTH-1:0]             ready;
        logic [DEPTH-1:0]             has_dst;
        logic [DEPTH-1:0][AREG_W-1:0] areg;
        logic [DEPTH-1:0][DATA_W-1:0] data;
    } slot_state_t;

    slot_state_t ent_d, ent_q;

    always_comb begin
        ent_d = ent_q;
        if (flush) begin
            ent_d.valid = '0;
            ent_d.ready = '0;
        end else begin
            if (retire) begin
                ent_d.valid[head_idx] = 1'b0;
                ent_d.ready[head_idx] = 1'b0;
            end
            if (wb_valid && ent_q.valid[wb_idx]) begin
                ent_d.ready[wb_idx] = 1'b1;
                ent_d.data[wb_idx]  = wb_data;
            end
            if (alloc) begin
                ent_d.valid[alloc_idx]   = 1'b1;
                ent_d.ready[alloc_idx]   = 1'b0;
                ent_d.has_dst[alloc_idx] = alloc_dst;
                ent_d.areg[alloc_idx]    = alloc_areg;
                ent_d.data[alloc_idx]    = '0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ent_q <= '0;
        else        ent_q <= ent_d;
    end

    assign head_valid = ent_q.valid[head_idx];
    assign head_ready = ent_q.ready[head_idx];
    assign head_dst   = ent_q.has_dst[head_idx];
    assign head_areg  = ent_q.areg[head_idx];
    assign head_data  = ent_q.data[head_idx];

    for (genvar g = 0; g < NUM_RD; g++) begin : g_rd
        logic [TAG_W-1:0] sel;
        assign sel = rd_tag[g*TAG_W +: TAG_W];
        assign rd_ready[g] = ent_q.valid[sel] & ent_q.ready[sel];
        assign rd_data[g*DATA_W +: DATA_W] = ent_q.data[sel];
    end

    // R6
    retire_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
        retire |-> (head_valid && head_ready));
    // R4
    wb_mark_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!flush && wb_valid && ent_q.valid[wb_idx] && !(retire && wb_idx == head_idx))
        |=> (ent_q.ready[$past(wb_idx)] && ent_q.data[$past(wb_idx)] == $past(wb_data)));
    // R4
    wb_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wb_valid && !ent_q.valid[wb_idx] && !(alloc && alloc_idx == wb_idx))
        |=> !ent_q.ready[$past(wb_idx)]);
    // R5
    alloc_fresh_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (alloc && !flush) |=> (ent_q.valid[$past(alloc_idx)] && !ent_q.ready[$past(alloc_idx)]));
endmodule

// File: rtl/reorder_buffer.sv
module reorder_buffer
    import rob_pkg::*;
#(
    parameter int unsigned DEPTH  = ROB_DEPTH_DEF,
    parameter int unsigned DATA_W = ROB_DATA_W_DEF,
    parameter int unsigned AREG_W = ROB_AREG_W_DEF,
    parameter int unsigned NUM_RD = ROB_RD_PORTS_DEF,
    parameter int unsigned TAG_W  = $clog2(DEPTH)
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     flush,
    input  logic                     disp_req,
    input  logic                     rs_avail,
    input  logic                     disp_has_dst,
    input  logic [AREG_W-1:0]        disp_areg,
    output logic                     disp_grant,
    output logic [TAG_W-1:0]         disp_tag,
    input  logic                     wb_valid,
    input  logic [TAG_W-1:0]         wb_tag,
    input  logic [DATA_W-1:0]        wb_data,
    input  logic [NUM_RD*TAG_W-1:0]  rd_tag,
    output logic [NUM_RD-1:0]        rd_ready,
    output logic [NUM_RD*DATA_W-1:0] rd_data,
    output logic                     commit_valid,
    output logic                     commit_wen,
    output logic [AREG_W-1:0]        commit_areg,
    output logic [DATA_W-1:0]        commit_data,
    output logic                     full,
    output logic                     empty
);
    logic [TAG_W-1:0] head_idx, tail_idx;
    logic             head_valid, head_ready, head_dst;
    logic             alloc, retire;

    assign disp_grant   = disp_req & rs_avail & ~full & ~flush;
    assign alloc        = disp_grant;
    assign disp_tag     = tail_idx;
    assign commit_valid = head_valid & head_ready & ~flush;
    assign retire       = commit_valid;
    assign commit_wen   = commit_valid & head_dst;

    rob_ctrl #(.DEPTH(DEPTH), .TAG_W(TAG_W)) u_ctrl (
        .clk   (clk),
        .rst_n (rst_n),
        .flush (flush),
        .alloc (alloc),
        .retire(retire),
        .head  (head_idx),
        .tail  (tail_idx),
        .full  (full),
        .empty (empty)
    );

    rob_store #(
        .DEPTH (DEPTH),
        .DATA_W(DATA_W),
        .AREG_W(AREG_W),
        .NUM_RD(NUM_RD),
        .TAG_W (TAG_W)
    ) u_store (
        .clk       (clk),
        .rst_n     (rst_n),
        .flush     (flush),
        .alloc     (alloc),
        .alloc_idx (tail_idx),
        .alloc_dst (disp_has_dst),
        .alloc_areg(disp_areg),
        .wb_valid  (wb_valid),
        .wb_idx    (wb_tag),
        .wb_data   (wb_data),
        .retire    (retire),
        .head_idx  (head_idx),
        .head_valid(head_valid),
        .head_ready(head_ready),
        .head_dst  (head_dst),
        .head_areg (commit_areg),
        .head_data (commit_data),
        .rd_tag    (rd_tag),
        .rd_ready  (rd_ready),
        .rd_data   (rd_data)
    );

    // R10
    empty_commit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        empty |-> !commit_valid);
    // R1
    flush_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        flush |-> (!disp_grant && !commit_valid));
    // R6
    head_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (commit_valid && !full) |=> !empty || !$past(disp_grant));
endmodule

// File: tb/tb_reorder_buffer.sv
module tb_reorder_buffer;
    localparam int TAG_W = 3;
    localparam int DW    = 32;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          flush, disp_req, rs_avail, disp_has_dst;
    logic [4:0]    disp_areg;
    logic          disp_grant;
    logic [2:0]    disp_tag;
    logic          wb_valid;
    logic [2:0]    wb_tag;
    logic [31:0]   wb_data;
    logic [5:0]    rd_tag;
    logic [1:0]    rd_ready;
    logic [63:0]   rd_data;
    logic          commit_valid, commit_wen;
    logic [4:0]    commit_areg;
    logic [31:0]   commit_data;
    logic          full, empty;

    int n_chk = 0;
    int n_bad = 0;

    always #5 clk = ~clk;

    reorder_buffer dut (
        .clk(clk), .rst_n(rst_n), .flush(flush),
        .disp_req(disp_req), .rs_avail(rs_avail), .disp_has_dst(disp_has_dst),
        .disp_areg(disp_areg), .disp_grant(disp_grant), .disp_tag(disp_tag),
        .wb_valid(wb_valid), .wb_tag(wb_tag), .wb_data(wb_data),
        .rd_tag(rd_tag), .rd_ready(rd_ready), .rd_data(rd_data),
        .commit_valid(commit_valid), .commit_wen(commit_wen),
        .commit_areg(commit_areg), .commit_data(commit_data),
        .full(full), .empty(empty)
    );

    typedef struct packed {
        logic        dreq;
        logic        ddst;
        logic [4:0]  dareg;
        logic        wv;
        logic [2:0]  wtag;
        logic [31:0] wdata;
        logic        egrant;
        logic [2:0]  etag;
        logic        ecv;
        logic        ewen;
        logic [4:0]  eareg;
        logic [31:0] edata;
    } vec_t;

    localparam vec_t VEC [10] = '{
        '{1'b1, 1'b1, 5'd3, 1'b0, 3'd0, 32'h0,  1'b1, 3'd0, 1'b0, 1'b0, 5'd0, 32'h0},
        '{1'b1, 1'b1, 5'd5, 1'b0, 3'd0, 32'h0,  1'b1, 3'd1, 1'b0, 1'b0, 5'd0, 32'h0},
        '{1'b1, 1'b0, 5'd0, 1'b0, 3'd0, 32'h0,  1'b1, 3'd2, 1'b0, 1'b0, 5'd0, 32'h0},
        '{1'b0, 1'b0, 5'd0, 1'b1, 3'd1, 32'h11, 1'b0, 3'd0, 1'b0, 1'b0, 5'd0, 32'h0},
        '{1'b0, 1'b0, 5'd0, 1'b1, 3'd2, 32'h22, 1'b0, 3'd0, 1'b0, 1'b0, 5'd0, 32'h0},
        '{1'b0, 1'b0, 5'd0, 1'b1, 3'd0, 32'hAA, 1'b0, 3'd0, 1'b0, 1'b0, 5'd0, 32'h0},
        '{1'b0, 1'b0, 5'd0, 1'b0, 3'd0, 32'h0,  1'b0, 3'd0, 1'b1, 1'b1, 5'd3, 32'hAA},
        '{1'b0, 1'b0, 5'd0, 1'b0, 3'd0, 32'h0,  1'b0, 3'd0, 1'b1, 1'b1, 5'd5, 32'h11},
        '{1'b0, 1'b0, 5'd0, 1'b0, 3'd0, 32'h0,  1'b0, 3'd0, 1'b1, 1'b0, 5'd0, 32'h22},
        '{1'b0, 1'b0, 5'd0, 1'b0, 3'd0, 32'h0,  1'b0, 3'd0, 1'b0, 1'b0, 5'd0, 32'h0}
    };

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic idle();
        flush = 1'b0; disp_req = 1'b0; rs_avail = 1'b1; disp_has_dst = 1'b0;
        disp_areg = '0; wb_valid = 1'b0; wb_tag = '0; wb_data = '0;
    endtask

    task automatic finish_run();
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    endtask

    initial begin
        repeat (5000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        idle();
        rd_tag = '0;
        repeat (2) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        chk("R1 reset empty", 64'(empty), 64'd1);
        chk("R1 reset full", 64'(full), 64'd0);
        chk("R10 reset commit", 64'(commit_valid), 64'd0);
        chk("R1 reset rd_ready", 64'(rd_ready), 64'd0);

        // Table: dispatch three (one without a destination), complete out of order (R7), retire in order
        for (int i = 0; i < 10; i++) begin
            @(negedge clk);
            idle();
            disp_req = VEC[i].dreq; disp_has_dst = VEC[i].ddst; disp_areg = VEC[i].dareg;
            wb_valid = VEC[i].wv; wb_tag = VEC[i].wtag; wb_data = VEC[i].wdata;
            #1;
            chk($sformatf("R2 row %0d grant", i), 64'(disp_grant), 64'(VEC[i].egrant));
            if (VEC[i].egrant)
                chk($sformatf("R9 row %0d tag", i), 64'(disp_tag), 64'(VEC[i].etag));
            chk($sformatf("R7 row %0d commit_valid", i), 64'(commit_valid), 64'(VEC[i].ecv));
            if (VEC[i].ecv) begin
                chk($sformatf("R8 row %0d commit_wen", i), 64'(commit_wen), 64'(VEC[i].ewen));
                chk($sformatf("R6 row %0d commit_data", i), 64'(commit_data), 64'(VEC[i].edata));
                if (VEC[i].ewen)
                    chk($sformatf("R6 row %0d commit_areg", i), 64'(commit_areg), 64'(VEC[i].eareg));
            end
        end
        chk("R10 drained empty", 64'(empty), 64'd1);

        // Fill all eight slots starting at tag 3: tags wrap 7 -> 0
        for (int i = 0; i < 8; i++) begin
            @(negedge clk);
            idle();
            disp_req = 1'b1; disp_has_dst = 1'b1; disp_areg = 5'(i + 8);
            #1;
            chk("R2 fill grant", 64'(disp_grant), 64'd1);
            chk("R9 fill tag", 64'(disp_tag), 64'((3 + i) % 8));
        end
        @(negedge clk);
        idle();
        rd_tag = {3'd4, 3'd3};
        #1;
        chk("R3 full flag", 64'(full), 64'd1);
        chk("R10 not empty", 64'(empty), 64'd0);
        chk("R5 fresh not ready", 64'(rd_ready), 64'd0);
        disp_req = 1'b1;
        #1;
        chk("R3 refuse when full", 64'(disp_grant), 64'd0);
        wb_valid = 1'b1; wb_tag = 3'd3; wb_data = 32'h33;

        @(negedge clk);
        idle();
        disp_req = 1'b1;
        #1;
        chk("R4 completed ready", 64'(rd_ready), 64'b01);
        chk("R5 read value", 64'(rd_data[31:0]), 64'h33);
        chk("R6 head commit", 64'(commit_valid), 64'd1);
        chk("R6 head areg", 64'(commit_areg), 64'd8);
        chk("R6 head data", 64'(commit_data), 64'h33);
        chk("R3 refuse with retire", 64'(disp_grant), 64'd0);

        @(negedge clk);
        idle();
        disp_req = 1'b1; rs_avail = 1'b0;
        #1;
        chk("R3 slot freed", 64'(full), 64'd0);
        chk("R2 scheduler busy", 64'(disp_grant), 64'd0);
        rs_avail = 1'b1;
        #1;
        chk("R2 grant again", 64'(disp_grant), 64'd1);
        chk("R9 reused tag", 64'(disp_tag), 64'd3);

        @(negedge clk);
        idle();
        #1;
        chk("R3 full again", 64'(full), 64'd1);
        chk("R5 reallocated not ready", 64'(rd_ready[0]), 64'd0);
        flush = 1'b1; disp_req = 1'b1;
        #1;
        chk("R1 no grant in flush", 64'(disp_grant), 64'd0);
        chk("R1 no commit in flush", 64'(commit_valid), 64'd0);

        @(negedge clk);
        idle();
        #1;
        chk("R1 flushed empty", 64'(empty), 64'd1);
        chk("R1 flushed full", 64'(full), 64'd0);
        chk("R1 flushed rd_ready", 64'(rd_ready), 64'd0);
        wb_valid = 1'b1; wb_tag = 3'd4; wb_data = 32'h44;

        @(negedge clk);
        idle();
        #1;
        chk("R4 free slot result dropped", 64'(rd_ready), 64'd0);
        disp_req = 1'b1; disp_has_dst = 1'b1; disp_areg = 5'd1;
        #1;
        chk("R1 first tag after flush", 64'(disp_tag), 64'd0);

        @(negedge clk);
        idle();
        #1;
        chk("R6 incomplete head held", 64'(commit_valid), 64'd0);
        chk("R10 one in flight", 64'(empty), 64'd0);

        finish_run();
    end
endmodule